// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block produces the chip-wide reset and gates the processor clock enable. It takes a raw active-low reset pin, a watchdog reset request, a flag saying the oscillator is running, a flag saying the flash controller has finished initializing, and a wake event that ends a power-down period. Every flop runs on the oscillator clock. A separate active-low power-on input clears the block asynchronously.

The reset pin passes through a synchronizer and then a debounce filter before the sequencer sees it. Either reset source restarts a wake-up counter. That counter advances only while the oscillator flag is high. The internal reset is released on a clock edge, and only when all four conditions hold together: the filtered pin is released, the oscillator runs, the counter has expired, and flash initialization is done.

The same counter is reused on a wake from power-down. In that case the internal reset stays released and only the run enable is held low until the count completes. All pins are plain control and status levels. There is no data stream and so no valid/ready handshake.

Top module: `rwk_top`

## Requirements
- R1: While `por_n` is low, `sys_rst_n` and `cpu_run_en` are both low, without waiting for a clock edge.
- R2: A low pulse on `rst_pin_n` that lasts fewer than FILT_LEN (default 4) consecutive clock samples has no effect on `sys_rst_n`. A low level held for FILT_LEN or more samples drives `sys_rst_n` low.
- R3: A `wdt_req` high for a single cycle drives `sys_rst_n` low on the next rising edge and starts a full reset sequence.
- R4: `sys_rst_n` rises only on a clock edge at which four conditions all hold: the filtered pin is released, `osc_ok` is high, the wake-up count has expired, and `flash_done` is high. If any one of them is missing, reset stays asserted for as long as it is missing.
- R5: The wake-up counter advances only on cycles where `osc_ok` is high, and every reset source or wake restarts it from zero. Reset or run enable is never released fewer than WAKE_CYCLES (default 4096) counted cycles after the last restart.
- R6: A `wake_evt` pulse while running leaves `sys_rst_n` high and drops `cpu_run_en` on the next edge. `cpu_run_en` stays low until the wake-up count expires and then returns high.
- R7: `cpu_run_en` is never high while `sys_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| rst_pin_n | input | 1 | Raw external reset pin, active low |
| wdt_req | input | 1 | Watchdog reset request, may be a one-cycle pulse |
| osc_ok | input | 1 | Oscillator running indication |
| flash_done | input | 1 | Flash controller initialization complete |
| wake_evt | input | 1 | Power-down wake event pulse |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| cpu_run_en | output | 1 | Processor clock run enable |

## Verification
The bound checker checks the following on every cycle:
- the run enable never leads the reset;
- a watchdog pulse takes effect on the next edge;
- a release always follows a cycle in which the oscillator and flash flags were high;
- no release of reset or run enable comes before a cycle counter in the checker has reached the wake-up length.

Other behaviour can only be shown by the bench scenarios:
- that pin pulses below the filter length are ignored while longer ones reset;
- that a missing oscillator or flash flag holds reset indefinitely;
- that a wake leaves the reset untouched;
- the exact release latency.

// File: rtl/rwk_pkg.sv
package rwk_pkg;
  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_WAKE  = 2'd1,
    PH_RUN   = 2'd2
  } rwk_phase_e;
endpackage

// File: rtl/rwk_deglitch.sv
// Synchronizes the raw reset pin and only accepts a new level after it has
// been seen on FILT_LEN consecutive clock samples.
module rwk_deglitch #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_n,
  output logic pin_rel
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_q;
  logic                   filt_q;
  logic                   sampled;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
  end

  assign sampled = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      filt_q <= 1'b0;
      run_q  <= '0;
    end else if (sampled != filt_q) begin
      if (run_q == CW'(FILT_LEN - 1)) begin
        filt_q <= sampled;
        run_q  <= '0;
      end else begin
        run_q <= run_q + CW'(1);
      end
    end else begin
      run_q <= '0;
    end
  end

  assign pin_rel = filt_q;
endmodule

// File: rtl/rwk_wake_timer.sv
// Wake-up counter: cleared by restart, advances only on ticks, saturates.
module rwk_wake_timer #(
  parameter int WAKE_CYCLES = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int TW = $clog2(WAKE_CYCLES + 1);

  logic [TW-1:0] cnt_q;

  assign expired = (cnt_q == TW'(WAKE_CYCLES));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 cnt_q <= '0;
    else if (restart)           cnt_q <= '0;
    else if (tick && !expired)  cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/rwk_seq.sv
// Phase sequencer: reset hold, wake wait, run. Outputs are registered.
module rwk_seq
  import rwk_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic pin_rel,
  input  logic wdt_req,
  input  logic osc_ok,
  input  logic flash_done,
  input  logic wake_evt,
  input  logic tmr_done,
  output logic restart,
  output logic rst_n_q,
  output logic run_q
);
  rwk_phase_e ph_q, ph_d;
  logic       src_hit;

  assign src_hit = !pin_rel || wdt_req;
  assign restart = src_hit || (ph_q == PH_RUN && wake_evt);

  always_comb begin
    ph_d = ph_q;
    if (src_hit) begin
      ph_d = PH_RESET;
    end else begin
      unique case (ph_q)
        PH_RESET: if (osc_ok && tmr_done && flash_done) ph_d = PH_RUN;
        PH_WAKE:  if (tmr_done) ph_d = PH_RUN;
        PH_RUN:   if (wake_evt) ph_d = PH_WAKE;
        default:  ph_d = PH_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph_q    <= PH_RESET;
      rst_n_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      rst_n_q <= (ph_d != PH_RESET);
      run_q   <= (ph_d == PH_RUN);
    end
  end
endmodule

// File: rtl/rwk_top.sv
module rwk_top #(
  parameter int WAKE_CYCLES = 4096,
  parameter int FILT_LEN    = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin_n,
  input  logic wdt_req,
  input  logic osc_ok,
  input  logic flash_done,
  input  logic wake_evt,
  output logic sys_rst_n,
  output logic cpu_run_en
);
  logic pin_rel;
  logic restart;
  logic tmr_done;

  rwk_deglitch #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(2)) u_filt (
    .clk     (clk),
    .por_n   (por_n),
    .pin_n   (rst_pin_n),
    .pin_rel (pin_rel)
  );

  rwk_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_tmr (
    .clk     (clk),
    .por_n   (por_n),
    .restart (restart),
    .tick    (osc_ok),
    .expired (tmr_done)
  );

  rwk_seq u_seq (
    .clk        (clk),
    .por_n      (por_n),
    .pin_rel    (pin_rel),
    .wdt_req    (wdt_req),
    .osc_ok     (osc_ok),
    .flash_done (flash_done),
    .wake_evt   (wake_evt),
    .tmr_done   (tmr_done),
    .restart    (restart),
    .rst_n_q    (sys_rst_n),
    .run_q      (cpu_run_en)
  );
endmodule

// File: rtl/rwk_checker.sv
module rwk_checker #(
  parameter int WAKE_CYCLES = 4096
) (
  input logic clk,
  input logic por_n,
  input logic rst_pin_n,
  input logic wdt_req,
  input logic osc_ok,
  input logic flash_done,
  input logic wake_evt,
  input logic sys_rst_n,
  input logic cpu_run_en
);
  localparam int SW = $clog2(WAKE_CYCLES + 1);

  // Counts oscillator-qualified cycles since the last watchdog or wake restart.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                           since_q <= '0;
    else if (wdt_req || (wake_evt && sys_rst_n)) since_q <= '0;
    else if (osc_ok && since_q != SW'(WAKE_CYCLES)) since_q <= since_q + SW'(1);
  end

  always @(negedge clk) begin
    if (por_n === 1'b0)
      p_por_clears_r1: assert (!sys_rst_n && !cpu_run_en);
  end

  p_wdt_resets_r3: assert property (@(posedge clk) disable iff (!por_n)
    wdt_req |=> !sys_rst_n);

  p_release_conds_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> $past(osc_ok && flash_done && !wdt_req));

  p_release_wait_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> since_q == SW'(WAKE_CYCLES));

  p_run_wait_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cpu_run_en) |-> since_q == SW'(WAKE_CYCLES));

  p_wake_gates_run_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wake_evt && sys_rst_n) |=> !cpu_run_en);

  p_run_under_rst_r7: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> !cpu_run_en);
endmodule

bind rwk_top rwk_checker #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_pin_n  (rst_pin_n),
  .wdt_req    (wdt_req),
  .osc_ok     (osc_ok),
  .flash_done (flash_done),
  .wake_evt   (wake_evt),
  .sys_rst_n  (sys_rst_n),
  .cpu_run_en (cpu_run_en)
);

// File: tb/test_rwk_top.sv
module test_rwk_top;
  localparam int W = 64;
  localparam int F = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_n, rst_pin_n, wdt_req, osc_ok, flash_done, wake_evt;
  logic sys_rst_n, cpu_run_en;

  int checks = 0;
  int errors = 0;

  rwk_top #(.WAKE_CYCLES(W), .FILT_LEN(F)) i_rwk_top (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin_n  (rst_pin_n),
    .wdt_req    (wdt_req),
    .osc_ok     (osc_ok),
    .flash_done (flash_done),
    .wake_evt   (wake_evt),
    .sys_rst_n  (sys_rst_n),
    .cpu_run_en (cpu_run_en)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_range(string req, string what, int act, int lo, int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic int exp_assert(int len);
    return (len >= F) ? 1 : 0;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Waits for sys_rst_n to rise, counting negedges; flags run enable under reset (R7).
  task automatic wait_rst(inout int n, inout int bad);
    while (sys_rst_n !== 1'b1 && n < 20 * W + 2000) begin
      if (cpu_run_en !== 1'b0) bad++;
      cyc(1);
      n++;
    end
  endtask

  // Waits for cpu_run_en to rise; counts cycles where reset dropped.
  task automatic wait_run(inout int n, inout int drops);
    while (cpu_run_en !== 1'b1 && n < 20 * W + 2000) begin
      if (sys_rst_n !== 1'b1) drops++;
      cyc(1);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int n, bad, drops;
    void'($urandom(32'd7411));
    por_n = 1'b0; rst_pin_n = 1'b0; wdt_req = 1'b0;
    osc_ok = 1'b0; flash_done = 1'b1; wake_evt = 1'b0;
    #3;
    chk("R1", "reset state sys_rst_n", sys_rst_n, 0);
    chk("R1", "reset state cpu_run_en", cpu_run_en, 0);
    cyc(3);
    por_n = 1'b1; rst_pin_n = 1'b1;

    // R4/R5: oscillator not running keeps reset, timer frozen
    cyc(4 * W);
    chk("R4", "reset held without oscillator", sys_rst_n, 0);
    osc_ok = 1'b1;
    n = 0; bad = 0;
    wait_rst(n, bad);
    chk_range("R5", "release latency after osc_ok", n, W, W + 3);
    chk("R7", "run enable while in reset", bad, 0);
    chk("R4", "run enable after release", cpu_run_en, 1);

    // R3/R4: watchdog pulse with flash not ready
    flash_done = 1'b0;
    wdt_req = 1'b1; cyc(1); wdt_req = 1'b0;
    chk("R3", "one-cycle watchdog asserts reset", sys_rst_n, 0);
    cyc(3 * W);
    chk("R4", "reset held without flash_done", sys_rst_n, 0);
    flash_done = 1'b1; cyc(1);
    chk("R4", "release one edge after flash_done", sys_rst_n, 1);

    // R3/R5: watchdog sequence length
    wdt_req = 1'b1; cyc(1); wdt_req = 1'b0;
    n = 1; bad = 0;
    wait_rst(n, bad);
    chk_range("R5", "watchdog release latency", n, W, W + 3);
    chk("R7", "run enable under watchdog reset", bad, 0);

    // R2: directed glitch lengths around the filter length
    rst_pin_n = 1'b0; cyc(F - 1); rst_pin_n = 1'b1; cyc(10);
    chk("R2", "short pin pulse ignored", sys_rst_n, 1);
    rst_pin_n = 1'b0; cyc(F); rst_pin_n = 1'b1; cyc(8);
    chk("R2", "full-length pin pulse resets", sys_rst_n, 0);
    n = 8; bad = 0;
    wait_rst(n, bad);
    chk_range("R5", "pin release latency", n, W, W + 10);

    // R6: wake from power-down
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0;
    chk("R6", "wake keeps reset released", sys_rst_n, 1);
    chk("R6", "wake drops run enable", cpu_run_en, 0);
    n = 1; drops = 0;
    wait_run(n, drops);
    chk_range("R6", "wake hold length", n, W, W + 3);
    chk("R6", "reset never dropped during wake", drops, 0);

    // R5: wake timer frozen while oscillator stopped
    wake_evt = 1'b1; cyc(1); wake_evt = 1'b0; osc_ok = 1'b0;
    cyc(3 * W);
    chk("R5", "wake hold while oscillator stopped", cpu_run_en, 0);
    osc_ok = 1'b1;
    n = 0; drops = 0;
    wait_run(n, drops);
    chk_range("R5", "wake resumes after osc_ok", n, W, W + 3);

    // R2: random pin pulse lengths
    for (int i = 0; i < 24; i++) begin
      int len;
      len = $urandom_range(1, 6);
      rst_pin_n = 1'b0; cyc(len); rst_pin_n = 1'b1; cyc(8);
      chk("R2", "random pin pulse outcome", (sys_rst_n === 1'b0) ? 1 : 0, exp_assert(len));
      if (sys_rst_n !== 1'b1) begin
        n = 0; bad = 0;
        wait_rst(n, bad);
        chk("R7", "run enable under pin reset", bad, 0);
      end
      cyc(2);
    end

    cyc(5);
    finish_run();
  end
endmodule